// File: doc/BRIEF.md
# External Pin Interrupt Sense Unit

This unit watches eight external interrupt pins and turns each into an active-high request line for a parent interrupt controller. Each pin first passes through a two-flop synchroniser. It is then judged by its own 2-bit sense mode, which selects level-low, falling-edge, rising-edge or both-edges behaviour. The outcome is held in a per-pin status bit. That status bit drives the pin's request line directly.

Software reaches two 32-bit registers over a simple single-cycle register bus. A write takes effect at the clock edge on which `reg_wr` is high. Read data is combinational from `reg_addr`. The status register sits at offset 0x10 and the sense register at offset 0x14. In an edge mode, software acknowledges an event by writing 0 to its status bit. In level-low mode the status bit tracks the pin, so such a write has no effect there.

Top module: `pin_irq_sense`

## Requirements
- R1: The status register is at offset 0x10, with pin n at bit n and bits 31:8 reading 0. The sense register is at offset 0x14, with pin n's mode at bits [2n+1:2n], bits 31:16 reading 0 and ignoring writes. Any other offset reads 0, and writes to it change nothing.
- R2: While reset is held, all status bits, all request lines and all sense fields read 0, so every pin starts in level-low mode.
- R3: With sense code 0 (level low), the status bit equals the inverse of the synchronised pin. A pin change shows on the status bit and request line after the third rising clock edge, and not after the second.
- R4: With sense code 1 (falling edge), a synchronised 1-to-0 transition sets the status bit, and a 0-to-1 transition does not.
- R5: With sense code 2 (rising edge), a synchronised 0-to-1 transition sets the status bit, and a 1-to-0 transition does not.
- R6: With sense code 3 (both edges), either transition sets the status bit.
- R7: In any edge mode, a set status bit stays set until software writes 0 to that bit at offset 0x10. Writing 1 to a status bit has no effect.
- R8: In level-low mode, writing 0 to a status bit does not clear it. The bit keeps following the pin.
- R9: If a matching edge and a clearing write to the same bit meet on one clock edge, the bit ends up set.
- R10: Request line n is active high and always equals status bit n as read at offset 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Raw external interrupt pins |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq_o | output | 8 | Active-high requests to the parent controller |

## Verification
The checker watches every pin on every cycle. It confirms that level-low status tracks the inverted synchronised sample, that edge-mode status neither drops without a clearing write nor rises without a transition, that a matching transition always sets the bit even against a clear, and that read data agrees with the request lines. Only the bench scenarios can show the end-to-end behaviour. These cover the exact three-edge latency from pin to request line, the per-mode outcome of each pin transition across all modes and pins, the mixed-mode patterns, and the reset contents of both registers.

// File: rtl/pis_pkg.sv
package pis_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'd0,
        SENSE_FALL = 2'd1,
        SENSE_RISE = 2'd2,
        SENSE_BOTH = 2'd3
    } sense_e;

    localparam logic [31:0] STATUS_OFS = 32'h10;
    localparam logic [31:0] SENSE_OFS  = 32'h14;

    // edge qualification for one pin: was = previous sample, now = current
    function automatic logic edge_match(input sense_e mode, input logic was, input logic now);
        logic hit;
        case (mode)
            SENSE_FALL: hit = was & ~now;
            SENSE_RISE: hit = ~was & now;
            SENSE_BOTH: hit = was ^ now;
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/pis_sync.sv
module pis_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = din;
        for (int i = 1; i < int'(STAGES); i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.chain[STAGES-1];

endmodule

// File: rtl/pis_detect.sv
module pis_detect
    import pis_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    localparam int unsigned SENSE_W = 2 * NUM_PINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] smp,
    input  logic [SENSE_W-1:0]  sense,
    output logic [NUM_PINS-1:0] prev,
    output logic [NUM_PINS-1:0] edge_hit
);

    typedef struct packed {
        logic [NUM_PINS-1:0] prev;
    } det_st_t;

    det_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = smp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prev = st_q.prev;

    for (genvar n = 0; n < int'(NUM_PINS); n++) begin : g_pin
        assign edge_hit[n] = edge_match(sense_e'(sense[2*n +: 2]), st_q.prev[n], smp[n]);
    end

endmodule

// File: rtl/pis_regs.sv
module pis_regs
    import pis_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    localparam int unsigned SENSE_W = 2 * NUM_PINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [NUM_PINS-1:0] smp,
    input  logic [NUM_PINS-1:0] edge_hit,
    output logic [DATA_W-1:0]   rdata,
    output logic [SENSE_W-1:0]  sense,
    output logic [NUM_PINS-1:0] status
);

    typedef struct packed {
        logic [NUM_PINS-1:0] status;
        logic [SENSE_W-1:0]  sense;
    } reg_st_t;

    reg_st_t st_d, st_q;

    logic hit_status, hit_sense;
    logic wdata_unused;

    assign hit_status   = (addr == ADDR_W'(STATUS_OFS));
    assign hit_sense    = (addr == ADDR_W'(SENSE_OFS));
    assign wdata_unused = ^wdata[DATA_W-1:SENSE_W];

    always_comb begin
        st_d = st_q;
        for (int n = 0; n < int'(NUM_PINS); n++) begin
            if (st_q.sense[2*n +: 2] == SENSE_LOW) begin
                st_d.status[n] = ~smp[n];
            end else begin
                // a matching edge outranks a simultaneous clear
                st_d.status[n] = (st_q.status[n] & ~(wr & hit_status & ~wdata[n]))
                                 | edge_hit[n];
            end
        end
        if (wr && hit_sense) begin
            st_d.sense = wdata[SENSE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (hit_status)     rdata[NUM_PINS-1:0] = st_q.status;
        else if (hit_sense) rdata[SENSE_W-1:0]  = st_q.sense;
    end

    assign sense  = st_q.sense;
    assign status = st_q.status;

endmodule

// File: rtl/pin_irq_sense.sv
module pin_irq_sense
    import pis_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned SYNC_LEN = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [NUM_PINS-1:0] irq_o
);

    localparam int unsigned SENSE_W = 2 * NUM_PINS;

    logic [NUM_PINS-1:0] smp_w, prev_w, edge_w, status_w;
    logic [SENSE_W-1:0]  sense_w;

    pis_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_LEN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_i),
        .dout (smp_w)
    );

    pis_detect #(.NUM_PINS(NUM_PINS)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp     (smp_w),
        .sense   (sense_w),
        .prev    (prev_w),
        .edge_hit(edge_w)
    );

    pis_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .smp     (smp_w),
        .edge_hit(edge_w),
        .rdata   (reg_rdata),
        .sense   (sense_w),
        .status  (status_w)
    );

    assign irq_o = status_w;

endmodule

// File: rtl/pis_chk.sv
module pis_chk
    import pis_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    localparam int unsigned SENSE_W = 2 * NUM_PINS
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic [DATA_W-1:0]   reg_rdata,
    input logic [NUM_PINS-1:0] irq_o,
    input logic [SENSE_W-1:0]  sense_v,
    input logic [NUM_PINS-1:0] smp_v,
    input logic [NUM_PINS-1:0] prev_v
);

    logic at_status, at_sense;
    assign at_status = (reg_addr == ADDR_W'(STATUS_OFS));
    assign at_sense  = (reg_addr == ADDR_W'(SENSE_OFS));

    // R10
    status_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_status |-> (reg_rdata == DATA_W'(irq_o)));

    // R1
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!at_status && !at_sense) |-> (reg_rdata == '0));

    for (genvar n = 0; n < int'(NUM_PINS); n++) begin : g_pin
        // R3
        level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sense_v[2*n +: 2] == 2'd0) |=> (irq_o[n] == !$past(smp_v[n])));

        // R7
        edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((sense_v[2*n +: 2] != 2'd0) && irq_o[n]
             && !(reg_wr && at_status && !reg_wdata[n])) |=> irq_o[n]);

        // R7
        no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((sense_v[2*n +: 2] != 2'd0) && !irq_o[n] && (smp_v[n] == prev_v[n]))
            |=> !irq_o[n]);

        // R9
        edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (((sense_v[2*n +: 2] == 2'd1) && prev_v[n] && !smp_v[n]) ||
             ((sense_v[2*n +: 2] == 2'd2) && !prev_v[n] && smp_v[n]) ||
             ((sense_v[2*n +: 2] == 2'd3) && (prev_v[n] != smp_v[n]))) |=> irq_o[n]);
    end

endmodule

bind pin_irq_sense pis_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq_o    (irq_o),
    .sense_v  (sense_w),
    .smp_v    (smp_w),
    .prev_v   (prev_w)
);

// File: tb/sim_pin_irq_sense.sv
module sim_pin_irq_sense;

    localparam logic [7:0] A_STAT = 8'h10;
    localparam logic [7:0] A_SENS = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pins = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = A_STAT;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  irq_o;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    pin_irq_sense u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (pins),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq_o    (irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = A_STAT;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = A_STAT;
        #1;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [7:0] model(input logic [15:0] s, input logic [7:0] st,
                                         input logic [7:0] o, input logic [7:0] nw);
        logic [7:0] r;
        for (int n = 0; n < 8; n++) begin
            case (s[2*n +: 2])
                2'd0:    r[n] = ~nw[n];
                2'd1:    r[n] = st[n] | (o[n] & ~nw[n]);
                2'd2:    r[n] = st[n] | (~o[n] & nw[n]);
                default: r[n] = st[n] | (o[n] ^ nw[n]);
            endcase
        end
        return r;
    endfunction

    function automatic logic [15:0] rep(input logic [1:0] m);
        return {8{m}};
    endfunction

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  e;
        string       rq;

        // R2: contents while reset is held
        repeat (3) @(negedge clk);
        rd(A_STAT, d); check("R2 status", d, 32'h0);
        rd(A_SENS, d); check("R2 sense", d, 32'h0);
        check("R2 irq", {24'h0, irq_o}, 32'h0);
        rst_n = 1'b1;
        settle();
        rd(A_STAT, d); check("R3 idle low pins", d, 32'hFF);

        // R3: latency, level-low pin 0 released high
        pins = 8'h01;
        @(negedge clk); @(negedge clk);
        check("R3 not after two edges", {31'h0, irq_o[0]}, 32'h1);
        @(negedge clk);
        check("R3 after three edges", {31'h0, irq_o[0]}, 32'h0);
        settle();

        // R1: address map
        wr(A_SENS, 32'hFFFF_E4E4);
        rd(A_SENS, d); check("R1 sense upper bits", d, 32'h0000_E4E4);
        rd(8'h18, d); check("R1 unmapped read", d, 32'h0);
        rd(8'h00, d); check("R1 unmapped read low", d, 32'h0);

        // mixed modes: pin n uses code n%4
        pins = 8'h00; settle(); wr(A_STAT, 32'h0);
        rd(A_STAT, d); check("R3 mixed base", d, 32'h11);
        pins = 8'hFF; settle();
        e = model(16'hE4E4, 8'h11, 8'h00, 8'hFF);
        rd(A_STAT, d); check("R6 mixed rise", d, {24'h0, e});
        wr(8'h18, 32'h0);
        rd(A_STAT, d); check("R1 unmapped write", d, {24'h0, e});
        pins = 8'h00; settle();
        e = model(16'hE4E4, e, 8'hFF, 8'h00);
        rd(A_STAT, d); check("R4 mixed fall", d, {24'h0, e});
        wr(A_STAT, 32'h0);
        rd(A_STAT, d); check("R8 mixed clear", d, 32'h11);

        // sweep every mode on every pin
        for (int m = 0; m < 4; m++) begin
            wr(A_SENS, {16'h0, rep(2'(m))});
            rd(A_SENS, d); check("R1 sense readback", d, {16'h0, rep(2'(m))});
            rq = (m == 0) ? "R3" : (m == 1) ? "R4" : (m == 2) ? "R5" : "R6";
            for (int n = 0; n < 8; n++) begin
                pins = 8'h00; settle(); wr(A_STAT, 32'h0);
                rd(A_STAT, d); check("R7 base", d, (m == 0) ? 32'hFF : 32'h0);

                pins = 8'(1 << n); settle();
                e = (m == 0) ? ~pins : (m >= 2) ? 8'(1 << n) : 8'h00;
                rd(A_STAT, d); check({rq, " rise"}, d, {24'h0, e});

                wr(A_STAT, 32'hFFFF_FFFF);
                rd(A_STAT, d); check("R7 write one", d, {24'h0, e});
                check("R10 line", {24'h0, irq_o}, {24'h0, e});

                pins = 8'h00; settle();
                e = (m == 0) ? 8'hFF : 8'(1 << n);
                rd(A_STAT, d); check({rq, " fall"}, d, {24'h0, e});

                wr(A_STAT, ~(32'h1 << n));
                rd(A_STAT, d);
                check((m == 0) ? "R8 clear ignored" : "R7 clear", d, (m == 0) ? 32'hFF : 32'h0);
            end
        end

        // R9: rising edge on pin 0 lands with a clear of pin 0
        wr(A_SENS, 32'h2);
        pins = 8'h00; settle(); wr(A_STAT, 32'h0);
        @(negedge clk); pins = 8'h01;
        @(negedge clk); @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h0;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(A_STAT, d); check("R9 edge beats clear", d & 32'h1, 32'h1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule